// File: doc/BRIEF.md
# ECG Front-End SPI Slave Emulator

This block stands in for an eight-channel biopotential acquisition front-end on an SPI bus, so that a host-side controller can be exercised without the real converter board. It answers the same kind of command protocol as such a part. It has a small bank of configuration registers that the host reads and writes in bursts over consecutive addresses. It has a continuous sampling mode in which a data-ready strobe marks each new frame, and the host then clocks the frame out. It also has a low-power state that the host leaves with a wake-up command, and the wake-up delay is modelled.

The SPI pins are sampled with the system clock through two-stage synchronisers. The bus runs in mode 0: MOSI is captured on the rising SCLK edge, MISO moves after the falling edge, and data is sent most significant bit first. Sample contents do not model any analog signal. Each frame carries a sequence number and the channel index, so a host can tell frames and channels apart. Each SCLK high phase and low phase must last at least six system clock cycles.

Top module: `ecg_fe_emulator`

## Requirements
- R1: After reset, drdy_n is high and spi_miso is low. Register 0 reads back the identity code (parameter ID_CODE, default 0x92), and registers 1 to NREG-1 (default NREG = 26) read back 0x00.
- R2: Bytes are shifted MSB first in SPI mode 0. Any byte position that has no defined response returns 0x00, and spi_miso stays low while spi_cs_n is high.
- R3: The register read command is one byte of the form 001a_aaaa, where a is the 5-bit start address. The next byte holds the register count minus one in bits [4:0]. The following count bytes return consecutive registers starting at a, and bytes after those return 0x00.
- R4: The register write command is 010a_aaaa, followed by a count-minus-one byte and then the data bytes. These are written to consecutive registers from a. Register 0 is read-only.
- R5: Addresses NREG to 31, reached directly or by a burst running past the end, read as 0x00 and ignore writes.
- R6: Command 0x10 starts continuous sampling, and drdy_n then falls once every SAMPLE_CYCLES clock cycles (default 4096). Command 0x11 stops it, after which no further falling edge of drdy_n occurs.
- R7: In continuous mode a readout returns a 27-byte frame. It starts with the status bytes 0xC0, 0x00, 0x00. Then, for each channel k from 0 to 7, it returns three bytes: k, then the high byte and then the low byte of a 16-bit frame sequence number. The sequence number is 0 for the first frame after reset and grows by one per frame. Bytes past the frame return 0x00.
- R8: A low drdy_n returns high at the first rising SCLK edge seen while spi_cs_n is low.
- R9: While continuous mode is on, register read and write commands are ignored, and register contents are left unchanged.
- R10: Command 0x04 enters sleep. While asleep, drdy_n stays high and every command except wake-up (0x02) and reset (0x06) is ignored, including register writes. Register reads return 0x00 while asleep.
- R11: After command 0x02, the block stays in the sleep behaviour for WAKE_CYCLES clock cycles (default 1024) and then resumes, including any continuous sampling that was on.
- R12: Command 0x06, accepted in any state, stops continuous mode, leaves sleep, clears the frame sequence number and restores every register to its reset value within 32 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock from the host, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| drdy_n | output | 1 | Frame-ready strobe, active low |

## Verification
The hardest situations to reach are the mode interactions: sleep entered while continuous sampling runs, a wake-up whose delay has not yet elapsed, and a reset issued while frames are streaming or while asleep. The stimulus reaches each one through ordered SPI command sequences. Inside each window it sends register reads and writes, so that ignored commands show up as unchanged read-back values. It counts drdy_n falling edges over spans longer than two sample periods, so that missing strobes become visible. Frame contents are checked across consecutive frames and again after a reset, so that the sequence number's start value and its step are both observed.

// File: rtl/ecg_emu_pkg.sv
package ecg_emu_pkg;
  localparam logic [7:0] OP_WAKE  = 8'h02;
  localparam logic [7:0] OP_SLEEP = 8'h04;
  localparam logic [7:0] OP_RESET = 8'h06;
  localparam logic [7:0] OP_START = 8'h10;
  localparam logic [7:0] OP_STOP  = 8'h11;
  localparam logic [2:0] OP_RREG_HI = 3'b001;
  localparam logic [2:0] OP_WREG_HI = 3'b010;

  localparam int STATUS_BYTES = 3;
  localparam int BYTES_PER_CH = 3;
  localparam logic [3:0] STATUS_HEAD = 4'hC;

  typedef enum logic [1:0] {PWR_ON, PWR_SLEEP, PWR_WAKING} pwr_e;
  typedef enum logic [1:0] {XF_NONE, XF_RREG, XF_WREG} xfer_e;
endpackage

// File: rtl/ecg_spi_link.sv
module ecg_spi_link #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_i,
  input  logic             cs_n_i,
  input  logic             mosi_i,
  input  logic [7:0]       tx_byte,
  output logic             miso_o,
  output logic             cs_act,
  output logic             sclk_rise,
  output logic             byte_done,
  output logic [7:0]       rx_byte,
  output logic [IDX_W-1:0] rx_idx,
  output logic [IDX_W-1:0] next_idx
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [2:0] sclk_s;
  logic [2:0] cs_s;
  logic [1:0] mosi_s;
  logic [2:0] bit_cnt;
  logic [7:0] rx_sr;
  logic [7:0] tx_sr;
  logic       rise_w, fall_w, cs_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_s <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk_i};
      cs_s   <= {cs_s[1:0], cs_n_i};
      mosi_s <= {mosi_s[0], mosi_i};
    end
  end

  assign rise_w    = sclk_s[1] & ~sclk_s[2];
  assign fall_w    = ~sclk_s[1] & sclk_s[2];
  assign cs_act    = ~cs_s[1];
  assign cs_start  = ~cs_s[1] & cs_s[2];
  assign sclk_rise = rise_w & cs_act;
  assign miso_o    = tx_sr[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt   <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
      rx_idx    <= '0;
      next_idx  <= '0;
    end else begin
      byte_done <= 1'b0;
      if (!cs_act) begin
        bit_cnt  <= '0;
        next_idx <= '0;
        tx_sr    <= '0;
      end else begin
        if (cs_start)
          tx_sr <= tx_byte;
        else if (fall_w)
          tx_sr <= (bit_cnt == 3'd0) ? tx_byte : {tx_sr[6:0], 1'b0};
        if (rise_w) begin
          rx_sr   <= {rx_sr[6:0], mosi_s[1]};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            byte_done <= 1'b1;
            rx_byte   <= {rx_sr[6:0], mosi_s[1]};
            rx_idx    <= next_idx;
            if (next_idx != IDX_MAX) next_idx <= next_idx + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ecg_regfile.sv
module ecg_regfile #(
  parameter int         NREG    = 26,
  parameter logic [7:0] ID_CODE = 8'h92,
  parameter int         AW      = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_req,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata,
  output logic          clr_busy
);
  localparam logic [AW-1:0] LAST = AW'(NREG - 1);

  logic [7:0]    mem [NREG];
  logic [AW-1:0] cptr;
  logic [7:0]    dflt;

  assign dflt = (cptr == '0) ? ID_CODE : 8'h00;

  always_ff @(posedge clk) begin
    if (rst || clr_req) begin
      clr_busy <= 1'b1;
      cptr     <= '0;
    end else if (clr_busy) begin
      if (cptr == LAST) clr_busy <= 1'b0;
      else cptr <= cptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (clr_busy) mem[cptr] <= dflt;
    else if (we && waddr <= LAST) mem[waddr] <= wdata;
    rdata <= (raddr <= LAST) ? mem[raddr] : 8'h00;
  end
endmodule

// File: rtl/ecg_frame_gen.sv
module ecg_frame_gen
  import ecg_emu_pkg::*;
#(
  parameter int NCH           = 8,
  parameter int SAMPLE_CYCLES = 4096,
  parameter int IDX_W         = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             run,
  input  logic             rd_edge,
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       fr_byte,
  output logic             drdy_n,
  output logic             fire
);
  localparam int FRAME_BYTES = STATUS_BYTES + NCH * BYTES_PER_CH;
  localparam int TW = (SAMPLE_CYCLES > 2) ? $clog2(SAMPLE_CYCLES) : 1;
  localparam logic [TW-1:0] T_LAST = TW'(SAMPLE_CYCLES - 1);

  logic [TW-1:0]    tmr;
  logic [15:0]      seq, lat;
  logic [IDX_W-1:0] k, ch, pos;

  assign fire = run && (tmr == T_LAST);

  always_ff @(posedge clk) begin
    if (rst || soft_rst || !run) tmr <= '0;
    else if (tmr == T_LAST) tmr <= '0;
    else tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      seq    <= '0;
      lat    <= '0;
      drdy_n <= 1'b1;
    end else begin
      if (fire) begin
        lat    <= seq;
        seq    <= seq + 16'd1;
        drdy_n <= 1'b0;
      end else if (!run || rd_edge) begin
        drdy_n <= 1'b1;
      end
    end
  end

  always_comb begin
    k   = idx - IDX_W'(STATUS_BYTES);
    ch  = k / IDX_W'(BYTES_PER_CH);
    pos = k % IDX_W'(BYTES_PER_CH);
    fr_byte = 8'h00;
    if (idx == '0) begin
      fr_byte = {STATUS_HEAD, 4'h0};
    end else if (idx >= IDX_W'(STATUS_BYTES) && idx < IDX_W'(FRAME_BYTES)) begin
      case (pos)
        IDX_W'(0): fr_byte = 8'(ch);
        IDX_W'(1): fr_byte = lat[15:8];
        default:   fr_byte = lat[7:0];
      endcase
    end
  end
endmodule

// File: rtl/ecg_fe_emulator.sv
module ecg_fe_emulator
  import ecg_emu_pkg::*;
#(
  parameter int         NREG          = 26,
  parameter int         NCH           = 8,
  parameter int         SAMPLE_CYCLES = 4096,
  parameter int         WAKE_CYCLES   = 1024,
  parameter logic [7:0] ID_CODE       = 8'h92
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic drdy_n
);
  localparam int FRAME_BYTES = STATUS_BYTES + NCH * BYTES_PER_CH;
  localparam int IDX_W = $clog2(FRAME_BYTES + 1);
  localparam int AW    = 5;
  localparam int PTR_W = AW + 1;
  localparam int WW    = (WAKE_CYCLES > 2) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [WW-1:0]    W_LAST  = WW'(WAKE_CYCLES - 1);
  localparam logic [PTR_W-1:0] NREG_P  = PTR_W'(NREG);
  localparam logic [IDX_W-1:0] IDX_TWO = IDX_W'(2);

  pwr_e              pwr_q;
  xfer_e             xfer_q;
  logic              cont_q;
  logic [PTR_W-1:0]  ptr_q, left_q;
  logic [WW-1:0]     wtmr_q;

  logic              cs_act, sclk_rise, byte_done, fire, run;
  logic [7:0]        rx_byte, tx_next, fr_byte, reg_rdata;
  logic [IDX_W-1:0]  rx_idx, next_idx;
  logic              soft_rst, data_phase, reg_we, clr_busy;

  ecg_spi_link #(.IDX_W(IDX_W)) link_i (
    .clk(clk), .rst(rst),
    .sclk_i(spi_sclk), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
    .tx_byte(tx_next), .miso_o(spi_miso),
    .cs_act(cs_act), .sclk_rise(sclk_rise), .byte_done(byte_done),
    .rx_byte(rx_byte), .rx_idx(rx_idx), .next_idx(next_idx)
  );

  ecg_regfile #(.NREG(NREG), .ID_CODE(ID_CODE), .AW(AW)) regs_i (
    .clk(clk), .rst(rst), .clr_req(soft_rst),
    .we(reg_we), .waddr(ptr_q[AW-1:0]), .wdata(rx_byte),
    .raddr(ptr_q[AW-1:0]), .rdata(reg_rdata), .clr_busy(clr_busy)
  );

  ecg_frame_gen #(.NCH(NCH), .SAMPLE_CYCLES(SAMPLE_CYCLES), .IDX_W(IDX_W)) frame_i (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .run(run),
    .rd_edge(sclk_rise), .idx(next_idx), .fr_byte(fr_byte),
    .drdy_n(drdy_n), .fire(fire)
  );

  assign run = cont_q && (pwr_q == PWR_ON);

  always_comb begin
    soft_rst   = byte_done && (rx_idx == '0) && (rx_byte == OP_RESET);
    data_phase = byte_done && (rx_idx >= IDX_TWO) && (xfer_q != XF_NONE) && (left_q != '0);
    reg_we     = data_phase && (xfer_q == XF_WREG) && (ptr_q != '0) && (ptr_q < NREG_P);
    if (run)
      tx_next = fr_byte;
    else if (xfer_q == XF_RREG && next_idx >= IDX_TWO && left_q != '0 && ptr_q < NREG_P && !clr_busy)
      tx_next = reg_rdata;
    else
      tx_next = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_q  <= PWR_ON;
      xfer_q <= XF_NONE;
      cont_q <= 1'b0;
      ptr_q  <= '0;
      left_q <= '0;
      wtmr_q <= '0;
    end else begin
      if (pwr_q == PWR_WAKING) begin
        if (wtmr_q == W_LAST) pwr_q <= PWR_ON;
        else wtmr_q <= wtmr_q + 1'b1;
      end
      if (!cs_act) xfer_q <= XF_NONE;
      if (byte_done) begin
        if (rx_idx == '0) begin
          if (rx_byte == OP_RESET) begin
            pwr_q  <= PWR_ON;
            cont_q <= 1'b0;
            xfer_q <= XF_NONE;
          end else if (pwr_q == PWR_SLEEP) begin
            if (rx_byte == OP_WAKE) begin
              pwr_q  <= PWR_WAKING;
              wtmr_q <= '0;
            end
          end else if (pwr_q == PWR_ON) begin
            case (rx_byte)
              OP_SLEEP: pwr_q  <= PWR_SLEEP;
              OP_START: cont_q <= 1'b1;
              OP_STOP:  cont_q <= 1'b0;
              default: begin
                if (!cont_q && rx_byte[7:5] == OP_RREG_HI) begin
                  xfer_q <= XF_RREG;
                  ptr_q  <= {1'b0, rx_byte[4:0]};
                end else if (!cont_q && rx_byte[7:5] == OP_WREG_HI) begin
                  xfer_q <= XF_WREG;
                  ptr_q  <= {1'b0, rx_byte[4:0]};
                end
              end
            endcase
          end
        end else if (rx_idx == IDX_W'(1)) begin
          if (xfer_q != XF_NONE) left_q <= {1'b0, rx_byte[4:0]} + 1'b1;
        end else if (data_phase) begin
          ptr_q  <= ptr_q + 1'b1;
          left_q <= left_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ecg_fe_emulator_chk.sv
module ecg_fe_emulator_chk
  import ecg_emu_pkg::*;
#(
  parameter int WAKE_CYCLES = 1024
) (
  input logic clk,
  input logic rst,
  input pwr_e pwr,
  input logic cont,
  input logic soft_rst,
  input logic drdy_n,
  input logic miso,
  input logic cs_act,
  input logic sclk_rise,
  input logic fire,
  input logic run
);
  logic [31:0] wcnt;

  always_ff @(posedge clk) begin
    if (rst || pwr != PWR_WAKING) wcnt <= '0;
    else wcnt <= wcnt + 32'd1;
  end

  AST_SLEEP_NO_DRDY: assert property (@(posedge clk) disable iff (rst)
    (pwr != PWR_ON && $past(pwr != PWR_ON)) |-> drdy_n); // R10

  AST_SLEEP_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
    (pwr != PWR_ON && !soft_rst) |=> $stable(cont)); // R10

  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!cs_act && $past(!cs_act)) |-> !miso); // R2

  AST_DRDY_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
    $fell(drdy_n) |-> $past(run)); // R6

  AST_DRDY_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && !fire) |=> drdy_n); // R8

  AST_WAKE_DELAY: assert property (@(posedge clk) disable iff (rst)
    (pwr == PWR_ON && $past(pwr == PWR_WAKING) && !$past(soft_rst)) |-> (wcnt == WAKE_CYCLES)); // R11
endmodule

bind ecg_fe_emulator ecg_fe_emulator_chk #(.WAKE_CYCLES(WAKE_CYCLES)) chk_i (
  .clk(clk), .rst(rst), .pwr(pwr_q), .cont(cont_q), .soft_rst(soft_rst),
  .drdy_n(drdy_n), .miso(spi_miso), .cs_act(cs_act), .sclk_rise(sclk_rise),
  .fire(fire), .run(run)
);

// File: tb/ecg_fe_emulator_tb_top.sv
module ecg_fe_emulator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int SAMPLE     = 4096;
  localparam int WAKE       = 1024;
  localparam logic [7:0] ID = 8'h92;

  // {address, write data, expected read-back}
  localparam logic [23:0] VEC [0:7] = '{
    {8'd3,  8'h5A, 8'h5A}, {8'd25, 8'hC3, 8'hC3}, {8'd0,  8'h11, 8'h92},
    {8'd26, 8'h77, 8'h00}, {8'd31, 8'hFF, 8'h00}, {8'd12, 8'h00, 8'h00},
    {8'd1,  8'hA5, 8'hA5}, {8'd17, 8'h3C, 8'h3C}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, drdy_n;

  int checks = 0, errors = 0;
  int n_falls = 0;
  time last_t = 0, prev_t = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecg_fe_emulator dut_i (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .drdy_n(drdy_n)
  );

  always @(negedge drdy_n) begin
    n_falls++;
    prev_t = last_t;
    last_t = $time;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      spi_mosi = tx[b];
      repeat (HALF) @(negedge clk);
      rx[b] = spi_miso;
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic cs_lo();
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (4*HALF) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] d;
    cs_lo(); spi_byte(op, d); cs_hi();
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [7:0] v);
    logic [7:0] d;
    cs_lo(); spi_byte({3'b010, a}, d); spi_byte(8'h00, d); spi_byte(v, d); cs_hi();
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [7:0] v);
    logic [7:0] d;
    cs_lo(); spi_byte({3'b001, a}, d); spi_byte(8'h00, d); spi_byte(8'h00, v); cs_hi();
  endtask

  task automatic wait_fall(input int target);
    for (int i = 0; i < 3*SAMPLE && n_falls < target; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] fexp(input int idx, input int seq);
    int k;
    if (idx == 0) return 8'hC0;
    if (idx < 3 || idx >= 27) return 8'h00;
    k = idx - 3;
    case (k % 3)
      0: return 8'(k / 3);
      1: return 8'(seq >> 8);
      default: return 8'(seq);
    endcase
  endfunction

  task automatic read_frame(input int seq, input string tag);
    logic [7:0] d;
    cs_lo();
    for (int i = 0; i < 28; i++) begin
      spi_byte(8'h00, d);
      chk(tag, d, fexp(i, seq));
    end
    cs_hi();
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (40) @(negedge clk);

    // R1 reset state
    chk("R1 drdy_n", drdy_n, 1);
    chk("R1 miso", spi_miso, 0);
    reg_read(5'd0, d);  chk("R1 id", d, ID);
    reg_read(5'd9, d);  chk("R1 reg9", d, 8'h00);

    // R4 R5 table of single writes with read-back
    for (int i = 0; i < 8; i++) begin
      reg_write(VEC[i][20:16], VEC[i][15:8]);
      reg_read(VEC[i][20:16], d);
      chk("R4/R5 table", d, VEC[i][7:0]);
    end

    // R3 R5 burst write past the end, burst read across it
    cs_lo();
    spi_byte({3'b010, 5'd23}, d); spi_byte(8'd3, d);
    spi_byte(8'h11, d); spi_byte(8'h22, d); spi_byte(8'h33, d); spi_byte(8'h44, d);
    cs_hi();
    cs_lo();
    spi_byte({3'b001, 5'd22}, d); spi_byte(8'd5, d);
    spi_byte(8'h00, d); chk("R3 burst r22", d, 8'h00);
    spi_byte(8'h00, d); chk("R3 burst r23", d, 8'h11);
    spi_byte(8'h00, d); chk("R3 burst r24", d, 8'h22);
    spi_byte(8'h00, d); chk("R3 burst r25", d, 8'h33);
    spi_byte(8'h00, d); chk("R5 burst r26", d, 8'h00);
    spi_byte(8'h00, d); chk("R5 burst r27", d, 8'h00);
    spi_byte(8'h00, d); chk("R2 past count", d, 8'h00);
    cs_hi();

    // R6 R7 R8 continuous mode
    n0 = n_falls;
    cmd(8'h10);
    wait_fall(n0 + 1);
    chk("R6 first drdy", n_falls, n0 + 1);
    cs_lo();
    chk("R8 drdy before sclk", drdy_n, 0);
    spi_byte(8'h00, d); chk("R7 status head", d, 8'hC0);
    chk("R8 drdy released", drdy_n, 1);
    for (int i = 1; i < 28; i++) begin
      spi_byte(8'h00, d);
      chk("R7 frame0", d, fexp(i, 0));
    end
    cs_hi();
    wait_fall(n0 + 2);
    chk("R6 interval", int'((last_t - prev_t) / CLK_PERIOD), SAMPLE);
    read_frame(1, "R7 frame1");

    // R9 register access ignored while streaming
    reg_write(5'd5, 8'hEE);
    n0 = n_falls;
    cmd(8'h11);
    repeat (2*SAMPLE + 100) @(negedge clk);
    chk("R6 stopped", n_falls - n0 <= 1 ? 1 : 0, 1);
    n0 = n_falls;
    repeat (SAMPLE + 100) @(negedge clk);
    chk("R6 no more strobes", n_falls, n0);
    reg_read(5'd5, d); chk("R9 write ignored", d, 8'h00);

    // R10 R11 sleep while streaming, then wake
    cmd(8'h10);
    cmd(8'h04);
    n0 = n_falls;
    reg_write(5'd6, 8'h66);
    reg_read(5'd0, d); chk("R10 read asleep", d, 8'h00);
    repeat (2*SAMPLE + 100) @(negedge clk);
    chk("R10 no drdy", n_falls, n0);
    chk("R10 drdy high", drdy_n, 1);
    cmd(8'h02);
    reg_read(5'd0, d); chk("R11 still waking", d, 8'h00);
    repeat (WAKE + 100) @(negedge clk);
    wait_fall(n0 + 1);
    chk("R11 streaming resumes", n_falls, n0 + 1);
    cmd(8'h11);
    reg_read(5'd0, d); chk("R11 awake id", d, ID);
    reg_read(5'd6, d); chk("R10 sleep write ignored", d, 8'h00);

    // R12 reset while streaming
    reg_write(5'd7, 8'h55);
    n0 = n_falls;
    cmd(8'h10);
    wait_fall(n0 + 1);
    cmd(8'h06);
    repeat (40) @(negedge clk);
    chk("R12 drdy high", drdy_n, 1);
    reg_read(5'd7, d); chk("R12 reg restored", d, 8'h00);
    reg_read(5'd3, d); chk("R12 reg3 restored", d, 8'h00);
    n0 = n_falls;
    cmd(8'h10);
    wait_fall(n0 + 1);
    read_frame(0, "R12 seq cleared");
    cmd(8'h11);

    // R12 reset while asleep
    cmd(8'h04);
    cmd(8'h06);
    repeat (40) @(negedge clk);
    reg_read(5'd0, d); chk("R12 reset leaves sleep", d, ID);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule